// File: doc/BRIEF.md
# Adaptive Structure Reconfiguration Controller

This controller decides, one measurement window at a time, which size setting an adaptive on-chip structure should use and which clock source should drive it. Each size setting has a clock period bound to it when the design is built. The controller counts retired instructions and elapsed cycles. When a window of a fixed number of retired instructions closes, it prices the window as cycles multiplied by the period of the active setting, which is proportional to time per instruction. It then keeps that figure as the latest one for the active setting.

The setting with the lowest stored cost is the challenger. A setting that has never been measured counts as free, so it is tried early. A two-bit saturating confidence counter for each setting must reach its top value before a change is made, so a single lucky window does not cause a reconfiguration. Every change follows a fixed order: ask the structure to empty the entries it is about to lose, hold the clock for a programmable time, move the clock select while it is held, release, and only then present the new size code.

A low-power request overrides prediction. It forces the smallest size together with a reserved slowest clock source. When the request drops, the controller returns to the smallest size with its normal clock. All pins are plain control levels; no data streams pass through the block.

Top module: `reconfig_mgr`

## Requirements
- R1: After reset, `size_code` and `clk_sel` are 0 and `clk_hold`, `drain_req` and `busy` are low.
- R2: While not busy and not in low-power mode, a window closes on the first cycle where the retired count so far plus that cycle's `retire_cnt` reaches `INTERVAL_INSTR`. Its cost is the number of cycles in the window, including that cycle, times the period `BASE_PERIOD + c*PERIOD_STEP` of the active setting c. That cost replaces the stored figure for c.
- R3: The challenger is the setting, other than the active one, with the lowest stored cost. A setting never measured counts as cost 0, and ties go to the lowest index.
- R4: At each window close, if the challenger's stored cost is strictly below the new cost, the challenger's confidence counter increments (saturating at 3) and all other counters clear; otherwise all counters clear. When the challenger's counter reaches 3, a switch to it starts. All counters clear whenever any switch starts.
- R5: `busy` and `drain_req` rise in the cycle after the edge that starts a switch. `drain_req` stays high, with `clk_hold` low, until `drain_done` is sampled high.
- R6: `clk_hold` is then high for exactly clamp(`hold_len`, 8, 32) consecutive cycles, starting in the cycle after `drain_done` is accepted. `hold_len` is sampled on that same edge.
- R7: `clk_sel` changes only while `clk_hold` is high, and it shows the new source in the last held cycle. Setting c uses clock source c; low-power mode uses source `NUM_CFG`.
- R8: After the hold there is exactly one cycle with `busy` high and `clk_hold` low. `size_code` keeps its old value through that cycle and shows the new setting in the next cycle, when `busy` falls.
- R9: Retired instructions and cycles while `busy` is high are not counted. The first window after a switch starts with the first cycle after `busy` falls.
- R10: If `low_power_req` is high while not busy and not in low-power mode, a switch to size 0 with clock source `NUM_CFG` starts. This discards the partial window and takes priority over a window close in that cycle. In low-power mode no windows are measured. When the request is low while not busy in low-power mode, a switch to size 0 with clock source 0 starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| low_power_req | input | 1 | Force minimum size and slowest clock |
| drain_done | input | 1 | Structure has emptied the entries to be disabled |
| hold_len | input | 6 | Requested clock hold length, clamped to 8..32 |
| size_code | output | $clog2(NUM_CFG) | Active structure size setting |
| clk_sel | output | $clog2(NUM_CFG+1) | Clock source select |
| clk_hold | output | 1 | Hold the processor clock |
| drain_req | output | 1 | Request cleanup before reconfiguration |
| busy | output | 1 | Reconfiguration in progress; counting frozen |

## Verification
The bench builds the block with four settings, a 3-bit retire count, a 24-instruction window and periods of 10, 13, 16 and 19. Windows therefore close every few cycles, and thousands of cycles cover many windows and switches. Retire rates that depend on the active size make the larger settings win in some phases and the smallest win in others. This drives the controller through exploration of unmeasured settings, confidence build-up and confidence resets, and it exercises both hold-length clamp limits and low-power entry in the middle of a window.

// File: rtl/rm_pkg.sv
package rm_pkg;

  typedef enum logic [2:0] {
    SQ_RUN     = 3'd0,
    SQ_DRAIN   = 3'd1,
    SQ_HOLD    = 3'd2,
    SQ_SELECT  = 3'd3,
    SQ_RELEASE = 3'd4
  } seq_state_t;

  localparam int unsigned CONF_W   = 2;
  localparam logic [CONF_W-1:0] CONF_TRIG = 2'd3;

endpackage

// File: rtl/rm_interval_meter.sv
module rm_interval_meter #(
  parameter int RET_W          = 3,
  parameter int INTERVAL_INSTR = 2000,
  parameter int CYC_W          = 16,
  parameter int NUM_CFG        = 4,
  parameter int CFG_W          = 2,
  parameter int PER_W          = 8,
  parameter int BASE_PERIOD    = 10,
  parameter int PERIOD_STEP    = 4,
  parameter int COST_W         = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [RET_W-1:0]  retire_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              done_o,
  output logic [COST_W-1:0] cost_o
);

  localparam int INSTR_W = $clog2(INTERVAL_INSTR + (1 << RET_W)) + 1;
  localparam logic [INSTR_W-1:0] LIMIT = INSTR_W'(INTERVAL_INSTR);

  logic [INSTR_W-1:0] acc_q;
  logic [INSTR_W-1:0] acc_sum;
  logic [CYC_W-1:0]   cyc_q;
  logic [CYC_W-1:0]   cyc_inc;
  logic [PER_W-1:0]   period_tab [NUM_CFG];
  logic [PER_W-1:0]   cur_period;

  // per-setting clock period, fixed at build time
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_period
    assign period_tab[g] = PER_W'(BASE_PERIOD + g * PERIOD_STEP);
  end

  assign cur_period = period_tab[cfg_i];
  assign acc_sum    = acc_q + INSTR_W'(retire_i);
  assign cyc_inc    = (&cyc_q) ? cyc_q : cyc_q + 1'b1;
  assign done_o     = en_i && (acc_sum >= LIMIT);
  assign cost_o     = COST_W'(cyc_inc) * COST_W'(cur_period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cyc_q <= '0;
    end else if (clr_i || done_o) begin
      acc_q <= '0;
      cyc_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_sum;
      cyc_q <= cyc_inc;
    end
  end

endmodule

// File: rtl/rm_predictor.sv
module rm_predictor
  import rm_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter int CFG_W   = 2,
  parameter int COST_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              clear_i,
  output logic              switch_o,
  output logic [CFG_W-1:0]  cand_o
);

  logic [COST_W-1:0] cost_tab [NUM_CFG];
  logic              seen_q   [NUM_CFG];
  logic [CONF_W-1:0] conf_q   [NUM_CFG];
  logic [COST_W-1:0] eff_cost [NUM_CFG];
  logic [COST_W-1:0] best;
  logic              found;
  logic              beat;
  logic [CONF_W-1:0] conf_inc;

  // unmeasured settings look free so they get tried
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_eff
    assign eff_cost[g] = seen_q[g] ? cost_tab[g] : '0;
  end

  always_comb begin
    cand_o = '0;
    best   = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (CFG_W'(i) != cfg_i) begin
        if (!found || (eff_cost[i] < best)) begin
          found  = 1'b1;
          best   = eff_cost[i];
          cand_o = CFG_W'(i);
        end
      end
    end
  end

  assign beat     = best < cost_i;
  assign conf_inc = (conf_q[cand_o] == CONF_TRIG) ? CONF_TRIG : conf_q[cand_o] + 1'b1;
  assign switch_o = sample_i && beat && (conf_inc == CONF_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CFG; i++) begin
        cost_tab[i] <= '0;
        seen_q[i]   <= 1'b0;
        conf_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (sample_i && (cfg_i == CFG_W'(i))) begin
          cost_tab[i] <= cost_i;
          seen_q[i]   <= 1'b1;
        end
        if (clear_i) begin
          conf_q[i] <= '0;
        end else if (sample_i) begin
          conf_q[i] <= (beat && (cand_o == CFG_W'(i))) ? conf_inc : '0;
        end
      end
    end
  end

endmodule

// File: rtl/rm_switch_seq.sv
module rm_switch_seq
  import rm_pkg::*;
#(
  parameter int CFG_W    = 2,
  parameter int SEL_W    = 3,
  parameter int HOLD_W   = 6,
  parameter int HOLD_MIN = 8,
  parameter int HOLD_MAX = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  tgt_size_i,
  input  logic [SEL_W-1:0]  tgt_sel_i,
  input  logic              drain_done_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  output logic [CFG_W-1:0]  size_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              hold_o,
  output logic              drain_o,
  output logic              busy_o
);

  localparam int CNT_W = $clog2(HOLD_MAX + 1);

  seq_state_t        state_q;
  logic [CFG_W-1:0]  tsize_q;
  logic [SEL_W-1:0]  tsel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  hold_cycles;

  always_comb begin
    if (int'(hold_len_i) < HOLD_MIN)      hold_cycles = CNT_W'(HOLD_MIN);
    else if (int'(hold_len_i) > HOLD_MAX) hold_cycles = CNT_W'(HOLD_MAX);
    else                                  hold_cycles = CNT_W'(hold_len_i);
  end

  assign drain_o = (state_q == SQ_DRAIN);
  assign hold_o  = (state_q == SQ_HOLD) || (state_q == SQ_SELECT);
  assign busy_o  = (state_q != SQ_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      tsize_q <= '0;
      tsel_q  <= '0;
      cnt_q   <= '0;
      size_o  <= '0;
      sel_o   <= '0;
    end else begin
      unique case (state_q)
        SQ_RUN: begin
          if (start_i) begin
            tsize_q <= tgt_size_i;
            tsel_q  <= tgt_sel_i;
            state_q <= SQ_DRAIN;
          end
        end
        SQ_DRAIN: begin
          if (drain_done_i) begin
            // hold phase: (len-1) cycles here plus one select cycle
            cnt_q   <= hold_cycles - CNT_W'(2);
            state_q <= SQ_HOLD;
          end
        end
        SQ_HOLD: begin
          if (cnt_q == '0) begin
            sel_o   <= tsel_q;
            state_q <= SQ_SELECT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_SELECT: begin
          state_q <= SQ_RELEASE;
        end
        SQ_RELEASE: begin
          size_o  <= tsize_q;
          state_q <= SQ_RUN;
        end
        default: state_q <= SQ_RUN;
      endcase
    end
  end

endmodule

// File: rtl/reconfig_mgr.sv
module reconfig_mgr #(
  parameter int NUM_CFG        = 4,
  parameter int RET_W          = 3,
  parameter int INTERVAL_INSTR = 2000,
  parameter int CYC_W          = 16,
  parameter int PER_W          = 8,
  parameter int BASE_PERIOD    = 10,
  parameter int PERIOD_STEP    = 4,
  parameter int HOLD_MIN       = 8,
  parameter int HOLD_MAX       = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RET_W-1:0]           retire_cnt,
  input  logic                       low_power_req,
  input  logic                       drain_done,
  input  logic [5:0]                 hold_len,
  output logic [$clog2(NUM_CFG)-1:0] size_code,
  output logic [$clog2(NUM_CFG+1)-1:0] clk_sel,
  output logic                       clk_hold,
  output logic                       drain_req,
  output logic                       busy
);

  localparam int CFG_W  = $clog2(NUM_CFG);
  localparam int SEL_W  = $clog2(NUM_CFG + 1);
  localparam int COST_W = CYC_W + PER_W;
  localparam logic [SEL_W-1:0] LP_SEL = SEL_W'(NUM_CFG);

  logic              running;
  logic              in_lp;
  logic              lp_enter;
  logic              lp_exit;
  logic              meas_en;
  logic              win_done;
  logic [COST_W-1:0] win_cost;
  logic              pred_switch;
  logic [CFG_W-1:0]  cand;
  logic              start;
  logic [CFG_W-1:0]  tgt_size;
  logic [SEL_W-1:0]  tgt_sel;

  assign running  = !busy;
  assign in_lp    = (clk_sel == LP_SEL);
  assign lp_enter = running && low_power_req && !in_lp;
  assign lp_exit  = running && !low_power_req && in_lp;
  assign meas_en  = running && !in_lp && !lp_enter;
  assign start    = lp_enter || lp_exit || pred_switch;

  always_comb begin
    if (lp_enter) begin
      tgt_size = '0;
      tgt_sel  = LP_SEL;
    end else if (lp_exit) begin
      tgt_size = '0;
      tgt_sel  = '0;
    end else begin
      tgt_size = cand;
      tgt_sel  = SEL_W'(cand);
    end
  end

  rm_interval_meter #(
    .RET_W(RET_W), .INTERVAL_INSTR(INTERVAL_INSTR), .CYC_W(CYC_W),
    .NUM_CFG(NUM_CFG), .CFG_W(CFG_W), .PER_W(PER_W),
    .BASE_PERIOD(BASE_PERIOD), .PERIOD_STEP(PERIOD_STEP), .COST_W(COST_W)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .en_i(meas_en), .clr_i(lp_enter),
    .retire_i(retire_cnt), .cfg_i(size_code),
    .done_o(win_done), .cost_o(win_cost)
  );

  rm_predictor #(
    .NUM_CFG(NUM_CFG), .CFG_W(CFG_W), .COST_W(COST_W)
  ) u_pred (
    .clk(clk), .rst_n(rst_n), .sample_i(win_done), .cost_i(win_cost),
    .cfg_i(size_code), .clear_i(start),
    .switch_o(pred_switch), .cand_o(cand)
  );

  rm_switch_seq #(
    .CFG_W(CFG_W), .SEL_W(SEL_W), .HOLD_W(6),
    .HOLD_MIN(HOLD_MIN), .HOLD_MAX(HOLD_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .tgt_size_i(tgt_size), .tgt_sel_i(tgt_sel),
    .drain_done_i(drain_done), .hold_len_i(hold_len),
    .size_o(size_code), .sel_o(clk_sel), .hold_o(clk_hold),
    .drain_o(drain_req), .busy_o(busy)
  );

endmodule

// File: rtl/reconfig_mgr_checker.sv
module reconfig_mgr_checker #(
  parameter int CFG_W  = 2,
  parameter int SEL_W  = 3,
  parameter int NUM_CFG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] size_code,
  input logic [SEL_W-1:0] clk_sel,
  input logic             clk_hold,
  input logic             drain_req,
  input logic             drain_done,
  input logic             busy
);

  logic [5:0] hold_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_run <= '0;
    else if (clk_hold) hold_run <= (&hold_run) ? hold_run : hold_run + 1'b1;
    else               hold_run <= '0;
  end

  p_drain_excl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drain_req && clk_hold));

  p_busy_opens_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> drain_req);

  p_hold_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_hold) |-> $past(drain_req && drain_done));

  p_hold_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hold |-> (hold_run < 6'd32));

  p_hold_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_hold) |-> (hold_run >= 6'd8));

  p_sel_only_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> clk_hold);

  p_size_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(size_code) |-> ($past(busy) && !$past(clk_hold) && !busy));

  p_lowpower_min_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (clk_sel == SEL_W'(NUM_CFG))) |-> (size_code == '0));

endmodule

bind reconfig_mgr reconfig_mgr_checker #(
  .CFG_W(CFG_W), .SEL_W(SEL_W), .NUM_CFG(NUM_CFG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .size_code(size_code), .clk_sel(clk_sel),
  .clk_hold(clk_hold), .drain_req(drain_req), .drain_done(drain_done),
  .busy(busy)
);

// File: tb/reconfig_mgr_test.sv
`timescale 1ns/1ps
module reconfig_mgr_test;

  localparam int NCFG = 4;
  localparam int RW   = 3;
  localparam int WIN  = 24;
  localparam int BASE = 10;
  localparam int STEP = 3;
  localparam int LPS  = NCFG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] retire_cnt = '0;
  logic          low_power_req = 1'b0;
  logic          drain_done = 1'b0;
  logic [5:0]    hold_len = '0;
  logic [1:0]    size_code;
  logic [2:0]    clk_sel;
  logic          clk_hold, drain_req, busy;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  reconfig_mgr #(
    .NUM_CFG(NCFG), .RET_W(RW), .INTERVAL_INSTR(WIN), .CYC_W(12),
    .PER_W(8), .BASE_PERIOD(BASE), .PERIOD_STEP(STEP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt),
    .low_power_req(low_power_req), .drain_done(drain_done),
    .hold_len(hold_len), .size_code(size_code), .clk_sel(clk_sel),
    .clk_hold(clk_hold), .drain_req(drain_req), .busy(busy)
  );

  // reference state
  int m_cost [NCFG];
  bit m_seen [NCFG];
  int m_conf [NCFG];
  int m_acc, m_cyc, m_cur;
  bit m_lp;
  bit post_sw;
  int n_switch = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int period_of(input int c);
    return BASE + c * STEP;
  endfunction

  function automatic int clampv(input int h);
    if (h < 8) return 8;
    if (h > 32) return 32;
    return h;
  endfunction

  function automatic int m_sel();
    return m_lp ? LPS : m_cur;
  endfunction

  // one clock edge of the reference, design assumed idle before the edge
  task automatic model_edge(input int ret, input bit lp, output bit sw,
                            output int tsize, output int tsel);
    sw = 0; tsize = 0; tsel = 0;
    if (lp && !m_lp) begin
      sw = 1; tsize = 0; tsel = LPS;
      m_acc = 0; m_cyc = 0;
      for (int i = 0; i < NCFG; i++) m_conf[i] = 0;
    end else if (!lp && m_lp) begin
      sw = 1; tsize = 0; tsel = 0;
      for (int i = 0; i < NCFG; i++) m_conf[i] = 0;
    end else if (!m_lp) begin
      if (m_acc + ret >= WIN) begin
        int cost, cand, best, nc;
        bit found;
        cost = (m_cyc + 1) * period_of(m_cur);
        found = 0; cand = 0; best = 0;
        for (int i = 0; i < NCFG; i++) begin
          int e;
          if (i == m_cur) continue;
          e = m_seen[i] ? m_cost[i] : 0;
          if (!found || e < best) begin found = 1; best = e; cand = i; end
        end
        m_cost[m_cur] = cost;
        m_seen[m_cur] = 1;
        nc = (best < cost) ? ((m_conf[cand] >= 3) ? 3 : m_conf[cand] + 1) : 0;
        for (int i = 0; i < NCFG; i++) m_conf[i] = 0;
        if (best < cost) m_conf[cand] = nc;
        if (nc == 3) begin
          sw = 1; tsize = cand; tsel = cand;
          for (int i = 0; i < NCFG; i++) m_conf[i] = 0;
        end
        m_acc = 0; m_cyc = 0;
        post_sw = 0;
      end else begin
        m_acc += ret;
        m_cyc += 1;
      end
    end
  endtask

  // entered at the negedge right after the starting edge
  task automatic do_switch(input int tsize, input int tsel, input string req);
    int old_size, old_sel, wt, hl, nh, last_sel;
    old_size = m_cur;
    old_sel  = m_sel();
    chk(busy && drain_req && !clk_hold, "R5", "drain opens after start",
        {busy, drain_req, clk_hold}, 3'b110);
    wt = $urandom_range(0, 4);
    for (int k = 0; k < wt; k++) begin
      retire_cnt = RW'($urandom_range(0, 7));
      @(posedge clk); @(negedge clk);
      chk(drain_req && !clk_hold, "R5", "drain held until done",
          {drain_req, clk_hold}, 2'b10);
    end
    case (n_switch)
      0: hl = 0;
      1: hl = 63;
      2: hl = 8;
      3: hl = 32;
      default: hl = $urandom_range(0, 63);
    endcase
    n_switch++;
    hold_len = 6'(hl);
    drain_done = 1'b1;
    retire_cnt = RW'($urandom_range(0, 7));
    @(posedge clk); @(negedge clk);
    drain_done = 1'b0;
    hold_len = 6'($urandom_range(0, 63));
    nh = 0; last_sel = -1;
    chk(int'(clk_sel) == old_sel, "R7", "source unchanged at hold start",
        int'(clk_sel), old_sel);
    while (clk_hold && nh < 40) begin
      last_sel = int'(clk_sel);
      nh++;
      retire_cnt = RW'($urandom_range(0, 7));
      @(posedge clk); @(negedge clk);
    end
    chk(nh == clampv(hl), "R6", "hold length", nh, clampv(hl));
    chk(last_sel == tsel, "R7", "source in last held cycle", last_sel, tsel);
    chk(busy && !clk_hold && int'(size_code) == old_size, "R8",
        "release cycle keeps old size", int'(size_code), old_size);
    @(posedge clk); @(negedge clk);
    chk(!busy && int'(size_code) == tsize, req, "new size after release",
        int'(size_code), tsize);
    chk(int'(clk_sel) == tsel, req, "new source after release",
        int'(clk_sel), tsel);
    m_cur = tsize;
    m_lp = (tsel == LPS);
    m_acc = 0; m_cyc = 0;
    post_sw = 1;
  endtask

  function automatic int pick_retire(input int kind, input int cur);
    int r;
    case (kind)
      0: r = $urandom_range(2, 5);
      1: begin
        r = 1 + 2 * cur + $urandom_range(0, 1);
        if (r > 7) r = 7;
      end
      default: r = $urandom_range(0, 7);
    endcase
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCFG; i++) begin m_cost[i] = 0; m_seen[i] = 0; m_conf[i] = 0; end
    m_acc = 0; m_cyc = 0; m_cur = 0; m_lp = 0; post_sw = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(size_code == 0 && clk_sel == 0, "R1", "reset size/source",
        {size_code, clk_sel}, 0);
    chk(!clk_hold && !drain_req && !busy, "R1", "reset handshake idle",
        {clk_hold, drain_req, busy}, 0);

    for (int ph = 0; ph < 14; ph++) begin
      int kind;
      bit lp;
      kind = (ph < 2) ? 1 : (ph == 2) ? 0 : $urandom_range(0, 2);
      lp = (ph == 5) || (ph == 9) || (ph > 9 && $urandom_range(0, 3) == 0);
      for (int cy = 0; cy < 250; cy++) begin
        int ret, tsize, tsel;
        bit sw;
        string tag;
        ret = pick_retire(kind, m_cur);
        retire_cnt = RW'(ret);
        low_power_req = lp;
        tag = m_lp ? "R10" : (post_sw ? "R9" : "R2");
        model_edge(ret, lp, sw, tsize, tsel);
        @(posedge clk); @(negedge clk);
        if (sw) begin
          do_switch(tsize, tsel, (tsel == LPS || lp != m_lp) ? "R10" : "R3");
        end else begin
          chk(!busy, m_lp ? "R10" : "R4", "no switch expected", busy, 0);
          chk(int'(size_code) == m_cur && int'(clk_sel) == m_sel(), tag,
              "setting steady", {size_code, clk_sel}, {m_cur[1:0], m_sel()[2:0]});
        end
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule